// File: doc/BRIEF.md
# Read Retry Controller with Local Error Detection

This block sits on the read path between a pipelined system bus and a cache or processor master. For each read it issues an address phase and waits through the data phase until the slave signals ready. It then spends one extra cycle comparing the result from a link error decoder against the returned word. If the word is clean, the block pulses a sample enable so the consumers capture the data. If the decoder reports a fault, the block keeps the sample enable low, pulses a replay request, and issues the same read a second time. The slave sees only two ordinary reads of one address. No response wire runs back to the slave.

On a pipelined bus the address lines have moved on to the next request by the time the check runs. The block therefore keeps the address of the beat in flight in its own register and drives that address for the repeated transfer, whatever the request inputs show. A retry costs one idle bus cycle followed by a full repeated read. A saturating failure counter limits how often one word is retried. When the limit is reached, a fatal pulse is raised and the block drops the transfer.

Top module: `rd_retry_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, bus_valid, sample_en, replay_req, retry_fatal and req_ack are all 0.
- R2: When idle with req_valid high, req_ack is 1 in that same cycle. In the following cycle bus_valid is 1 and bus_addr equals the req_addr that was accepted.
- R3: The controller stays in the data phase until data_ready is 1. The decoder is consulted only in the cycle after the one in which data_ready is seen high, so sample_en is 0 in the data_ready cycle itself.
- R4: In the check cycle with dec_err = 0, sample_en is 1 for exactly that cycle, and replay_req and retry_fatal are 0.
- R5: In the check cycle with dec_err = 1 and the failure limit not yet reached, sample_en is 0 and replay_req is 1.
- R6: After a replay request, the next cycle has bus_valid = 0. In the cycle after that, bus_valid = 1 and bus_addr equals the address of the failed read, independent of the current req_addr.
- R7: During the data phase and the check cycle, bus_valid is 0 and bus_addr follows req_addr. This models the pipelined next address moving ahead on the bus.
- R8: A failure counter counts consecutive decoder errors on one read. On the MAX_FAIL-th error (default 3), retry_fatal is 1 for that check cycle, replay_req and sample_en are 0, and the controller returns to idle. The counter restarts at 0 for each newly accepted request.
- R9: A dec_err value outside the check cycle has no effect: it raises neither sample_en, replay_req nor retry_fatal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Master wants a read |
| req_addr | input | AW | Requested read address |
| req_ack | output | 1 | Request taken this cycle |
| bus_valid | output | 1 | Address phase of a read transfer on the bus |
| bus_addr | output | AW | Address lines toward the bus |
| data_ready | input | 1 | Slave read data valid this cycle |
| dec_err | input | 1 | Link decoder error flag, evaluated in the check cycle |
| sample_en | output | 1 | Consumers capture the returned word |
| replay_req | output | 1 | Repeat-last-transfer pulse |
| retry_fatal | output | 1 | Failure limit reached, transfer abandoned |

## Verification
The bench drives random error patterns and random numbers of wait states. It changes req_addr on every cycle after an address phase, so a controller that reissued from the live request lines would put a wrong address on the bus when it repeats a read. It raises dec_err at random during wait cycles and in the data_ready cycle. A design that checked the decoder a cycle too early, or that ignored the phase, would then emit stray sample or replay pulses. It runs one read to exactly the failure limit, followed by a read with MAX_FAIL-1 failures. An off-by-one counter, or one that did not restart per request, would signal fatal one retry early or late, or would wrongly mark the second read fatal.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ADDR,
    RS_DWAIT,
    RS_CHECK,
    RS_GAP,
    RS_REISSUE
  } rrc_state_e;
endpackage

// File: rtl/rrc_addr_hold.sv
module rrc_addr_hold #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/rrc_fail_cnt.sv
module rrc_fail_cnt #(
  parameter int MAX_FAIL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_FAIL + 1);
  localparam logic [CW-1:0] LIM = CW'(MAX_FAIL);
  localparam logic [CW-1:0] LAST = CW'(MAX_FAIL - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                     cnt_d = '0;
    else if (inc && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LAST);

  // R8: the count never passes the limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R8: a new request restarts the count
  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/rrc_fsm.sv
module rrc_fsm
  import rrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       data_ready,
  input  logic       dec_err,
  input  logic       at_limit,
  output rrc_state_e state,
  output logic       req_ack,
  output logic       issue,
  output logic       sample_en,
  output logic       replay_req,
  output logic       fatal
);
  rrc_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    req_ack    = 1'b0;
    sample_en  = 1'b0;
    replay_req = 1'b0;
    fatal      = 1'b0;
    case (st_q)
      RS_IDLE: begin
        if (req_valid) begin
          req_ack = 1'b1;
          st_d    = RS_ADDR;
        end
      end
      RS_ADDR:    st_d = RS_DWAIT;
      RS_DWAIT:   if (data_ready) st_d = RS_CHECK;
      RS_CHECK: begin
        if (!dec_err) begin
          sample_en = 1'b1;
          st_d      = RS_IDLE;
        end else if (at_limit) begin
          fatal = 1'b1;
          st_d  = RS_IDLE;
        end else begin
          replay_req = 1'b1;
          st_d       = RS_GAP;
        end
      end
      RS_GAP:     st_d = RS_REISSUE;
      RS_REISSUE: st_d = RS_DWAIT;
      default:    st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
  assign issue = (st_q == RS_ADDR) || (st_q == RS_REISSUE);

  // R3: the check cycle is entered only from a ready data phase
  p_check_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_CHECK) |-> $past(data_ready) && $past(st_q) == RS_DWAIT);
  // R9: no decision pulse outside the check cycle
  p_pulse_in_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en || replay_req || fatal) |-> st_q == RS_CHECK);
endmodule

// File: rtl/rd_retry_ctrl.sv
module rd_retry_ctrl #(
  parameter int AW       = 16,
  parameter int MAX_FAIL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ack,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  input  logic          data_ready,
  input  logic          dec_err,
  output logic          sample_en,
  output logic          replay_req,
  output logic          retry_fatal
);
  import rrc_pkg::*;

  rrc_state_e    state;
  logic          issue;
  logic          at_limit;
  logic          fail_seen;
  logic [AW-1:0] held_addr;

  rrc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .data_ready (data_ready),
    .dec_err    (dec_err),
    .at_limit   (at_limit),
    .state      (state),
    .req_ack    (req_ack),
    .issue      (issue),
    .sample_en  (sample_en),
    .replay_req (replay_req),
    .fatal      (retry_fatal)
  );

  rrc_addr_hold #(.AW(AW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (req_ack),
    .d     (req_addr),
    .q     (held_addr)
  );

  assign fail_seen = replay_req | retry_fatal;

  rrc_fail_cnt #(.MAX_FAIL(MAX_FAIL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (req_ack),
    .inc      (fail_seen),
    .at_limit (at_limit)
  );

  assign bus_valid = issue;
  assign bus_addr  = issue ? held_addr : req_addr;

  // R2: accepted address appears on the bus next cycle
  p_issue_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> bus_valid && bus_addr == $past(req_addr));
  // R5: at most one decision outcome per check
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sample_en, replay_req, retry_fatal}) <= 1);
  // R6: a replay is followed by one idle bus cycle
  p_gap_after_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |=> !bus_valid);
  // R6: the repeated read carries the failed address
  p_reissue_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(replay_req) |=> bus_valid && bus_addr == $past(held_addr, 2));
  // R4: sample enable is never raised on the data_ready cycle itself
  p_sample_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !bus_valid && $past(data_ready));
endmodule

// File: tb/rd_retry_ctrl_tb_top.sv
module rd_retry_ctrl_tb_top;
  localparam int AW = 16;
  localparam int MAX_FAIL = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, data_ready, dec_err;
  logic [AW-1:0] req_addr;
  logic          req_ack, bus_valid, sample_en, replay_req, retry_fatal;
  logic [AW-1:0] bus_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rd_retry_ctrl #(.AW(AW), .MAX_FAIL(MAX_FAIL)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ack(req_ack), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .data_ready(data_ready), .dec_err(dec_err), .sample_en(sample_en),
    .replay_req(replay_req), .retry_fatal(retry_fatal)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    return AW'($urandom);
  endfunction

  // expected outcome of a check cycle, from R4/R5/R8
  function automatic int outcome(int fails_before, bit err);
    if (!err) return 0;
    if (fails_before + 1 >= MAX_FAIL) return 2;
    return 1;
  endfunction

  task automatic run_read(input logic [AW-1:0] a, input int nerr);
    int fails = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; data_ready = 0; dec_err = 0;
    #1 chk("R2", "req_ack", req_ack, 1);
    @(negedge clk);
    req_valid = 0; req_addr = rnd_addr();
    #1 chk("R2", "bus_valid", bus_valid, 1);
    chk("R2", "bus_addr", bus_addr, a);
    while (1) begin
      int w = $urandom % 3;
      int res;
      bit e;
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        data_ready = 0; dec_err = 1'($urandom); req_addr = rnd_addr();
        #1 chk("R7", "bus_valid in wait", bus_valid, 0);
        chk("R7", "lookahead addr", bus_addr, req_addr);
        chk("R9", "pulses in wait", {sample_en, replay_req, retry_fatal}, 0);
      end
      @(negedge clk);
      data_ready = 1; dec_err = 1'($urandom);
      #1 chk("R3", "sample on ready cycle", sample_en, 0);
      chk("R9", "pulses on ready cycle", {replay_req, retry_fatal}, 0);
      @(negedge clk);
      data_ready = 0; e = (fails < nerr); dec_err = e; req_addr = rnd_addr();
      res = outcome(fails, e);
      #1 chk("R7", "lookahead in check", bus_addr, req_addr);
      if (res == 0) begin
        chk("R4", "sample_en", sample_en, 1);
        chk("R4", "replay/fatal", {replay_req, retry_fatal}, 0);
        break;
      end
      if (res == 2) begin
        chk("R8", "retry_fatal", retry_fatal, 1);
        chk("R8", "sample/replay", {sample_en, replay_req}, 0);
        break;
      end
      fails++;
      chk("R5", "replay_req", replay_req, 1);
      chk("R5", "sample_en", sample_en, 0);
      @(negedge clk);
      dec_err = 0; req_addr = rnd_addr();
      #1 chk("R6", "idle gap", bus_valid, 0);
      @(negedge clk);
      req_addr = rnd_addr();
      #1 chk("R6", "reissue valid", bus_valid, 1);
      chk("R6", "reissue addr", bus_addr, a);
    end
    @(negedge clk);
    dec_err = 0;
    #1 chk("R8", "back to idle", {bus_valid, sample_en, replay_req}, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; req_valid = 0; req_addr = '0; data_ready = 0; dec_err = 0;
    repeat (3) @(negedge clk);
    #1 chk("R1", "outputs in reset",
           {req_ack, bus_valid, sample_en, replay_req, retry_fatal}, 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk("R1", "outputs after reset",
           {req_ack, bus_valid, sample_en, replay_req, retry_fatal}, 0);
    run_read(16'h1234, 0);
    run_read(16'h00ff, 1);
    run_read(16'hbeef, 2);
    run_read(16'hdead, MAX_FAIL);   // R8 exact limit
    run_read(16'hdead, MAX_FAIL - 1); // R8 counter restarts
    for (int k = 0; k < 200; k++) run_read(rnd_addr(), $urandom % (MAX_FAIL + 1));
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule